// File: doc/BRIEF.md
# Program and Erase Status Reporter

This block gives a host that reads a flash device a way to see when an internal write operation has finished. A one-cycle start pulse launches an operation: a byte program, a chip erase or a lockout set. A down-counter then stands in for the self-timed array operation. While the counter runs, the block replaces the array read data with a status byte. Bit 7 carries a data-polling value. Bit 6 carries a bit that flips on every read. When the count expires, the block goes back to passing array data through, and the host does not have to issue any command.

The operation lengths are parameters counted in clock cycles. Each kind of operation has a typical setting and a maximum setting, and one parameter chooses which of the two is used. A power-on counter blocks every start request for a fixed number of cycles after reset.

Top module: `flash_status_reporter`

## Requirements
- R1: While reset is asserted and afterwards with no operation running, `busy` is 0 and `dout` equals `array_data`.
- R2: A start accepted with `op` = 2'b00 (byte program) holds `busy` high for exactly PROG_TYP_CYC cycles, or PROG_MAX_CYC cycles when USE_MAX is 1.
- R3: A start accepted with `op` = 2'b01 (chip erase) or 2'b10 (lockout set) holds `busy` high for exactly ERASE_TYP_CYC cycles, or ERASE_MAX_CYC cycles when USE_MAX is 1.
- R4: During a byte program, `dout[7]` is the complement of `wdata[7]` as captured at the accepted start.
- R5: During an erase or a lockout set, `dout[7]` reads 0.
- R6: `dout[6]` is 0 when an operation starts. It inverts once for each falling edge of `rd_n` while `busy` is high, and a strobe held low over several clocks counts as one read. With no falling edge it holds its value.
- R7: While `busy` is high, `dout[5:0]` reads 0.
- R8: Once `busy` falls, `dout` equals `array_data` again with no host action.
- R9: A start pulse while `busy` is high is ignored: it changes neither the remaining duration nor `dout[7]`.
- R10: A start pulse within the first PWRON_CYC cycles after reset release is ignored.
- R11: A start with `op` = 2'b11 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | Operation kind: 00 program, 01 erase, 10 lockout set, 11 none |
| wdata | input | 8 | Last byte written to the array (program data) |
| array_data | input | 8 | Normal read data from the array |
| rd_n | input | 1 | Read strobe, active low |
| dout | output | 8 | Read data seen by the host: status while busy, array data otherwise |
| busy | output | 1 | High while the modelled operation is in progress |

## Verification
The bench measures each operation's busy window cycle by cycle. A counter that is off by one, or that uses the wrong length for a kind of operation, therefore shows up as a duration mismatch. The read strobe is held low across three clocks and then pulsed again. A toggle that followed the strobe level rather than its falling edge would flip more than once on the long read, and the expected bit-6 sequence would break. Start pulses are also sent during an operation, during the power-on window and with the unused op code. A design that accepted any of them would raise `busy`, stretch the operation or flip the polling bit. The array data changes while busy, so a reporter that leaked pass-through data during the status window would be caught.

// File: rtl/flash_status_reporter.sv
module flash_status_reporter #(
  parameter int PROG_TYP_CYC  = 10,
  parameter int PROG_MAX_CYC  = 50,
  parameter int ERASE_TYP_CYC = 40,
  parameter int ERASE_MAX_CYC = 400,
  parameter int PWRON_CYC     = 20,
  parameter bit USE_MAX       = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op,
  input  logic [7:0] wdata,
  input  logic [7:0] array_data,
  input  logic       rd_n,
  output logic [7:0] dout,
  output logic       busy
);

  localparam int PROG_CYC  = USE_MAX ? PROG_MAX_CYC : PROG_TYP_CYC;
  localparam int ERASE_CYC = USE_MAX ? ERASE_MAX_CYC : ERASE_TYP_CYC;
  localparam int LONGEST   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW        = $clog2(LONGEST + 1);
  localparam int PW        = $clog2(PWRON_CYC + 2);
  localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] MAX_LOAD   = CW'(LONGEST - 1);
  localparam logic [PW-1:0] PWR_END    = PW'(PWRON_CYC);

  logic [PW-1:0] pwr_cnt;
  logic [CW-1:0] cnt;
  logic          poll, tgl, rd_q;

  wire pwr_ok  = (pwr_cnt == PWR_END);
  wire rd_fall = rd_q & ~rd_n;
  wire accept  = start & pwr_ok & ~busy & (op != 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_cnt <= '0;
    else if (!pwr_ok) pwr_cnt <= pwr_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b1;
    else rd_q <= rd_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      poll <= 1'b0;
      tgl  <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= (op == 2'b00) ? PROG_LOAD : ERASE_LOAD;
      poll <= (op == 2'b00) ? ~wdata[7] : 1'b0;
      tgl  <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else cnt <= cnt - 1'b1;
      if (rd_fall) tgl <= ~tgl;
    end
  end

  assign dout = busy ? {poll, tgl, 6'b0} : array_data;

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != '0 && start |=> busy && $stable(dout[7])); // R9
  AST_PWRON_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok && !busy |=> !busy); // R10
  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != '0 && !rd_fall |=> $stable(dout[6])); // R6
  AST_POLL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != '0 |=> $stable(dout[7])); // R4
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cnt) == '0); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= MAX_LOAD); // R3

endmodule

// File: tb/tb_flash_status_reporter.sv
module tb_flash_status_reporter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] array_data = 8'h5A;
  logic       rd_n = 1'b1;
  logic [7:0] dout;
  logic       busy;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_status_reporter dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wdata(wdata),
    .array_data(array_data), .rd_n(rd_n), .dout(dout), .busy(busy)
  );

  // {op, wdata, expected bit 7 while busy, expected duration}
  localparam logic [18:0] VEC [0:3] = '{
    {2'b00, 8'h80, 1'b0, 8'd10},
    {2'b00, 8'h35, 1'b1, 8'd10},
    {2'b01, 8'h7F, 1'b0, 8'd40},
    {2'b10, 8'hFF, 1'b0, 8'd40}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [7:0] wd, input logic d7,
                        input int dur, input bit poke);
    int k;
    logic exp_t;
    logic nrd;
    @(negedge clk);
    start = 1'b1; op = o; wdata = wd;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    exp_t = 1'b0;
    while (busy && k < 1000) begin
      chk("R4/R5 poll bit", dout[7], d7);
      chk("R7 low bits", dout[5:0], 6'd0);
      if (k <= 8) chk("R6 toggle", dout[6], exp_t);
      nrd = !(k inside {2, 3, 4, 6});
      if (rd_n && !nrd) exp_t = ~exp_t;
      rd_n = nrd;
      if (k == 5) array_data = 8'hC3;
      start = poke && (k == 3);
      if (poke && k == 3) begin op = 2'b01; wdata = ~wd; end
      k++;
      @(negedge clk);
    end
    start = 1'b0;
    rd_n = 1'b1;
    chk((o == 2'b00) ? "R2 duration" : "R3 duration", k - 1, dur);
    chk("R8 return to array", dout, array_data);
    array_data = 8'h5A;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 1'b0);
    chk("R1 dout in reset", dout, array_data);
    rst_n = 1'b1;
    @(negedge clk);
    start = 1'b1; op = 2'b00; wdata = 8'h00;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R10 early start ignored", busy, 1'b0);
    chk("R10 early dout", dout, array_data);
    repeat (25) @(negedge clk);
    chk("R1 idle busy", busy, 1'b0);
    start = 1'b1; op = 2'b11;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R11 op 11 ignored", busy, 1'b0);
    chk("R11 dout", dout, array_data);
    for (int i = 0; i < 4; i++)
      run_op(VEC[i][18:17], VEC[i][16:9], VEC[i][8], int'(VEC[i][7:0]), 1'b0);
    // R9: start during a program must not stretch it or flip the poll bit
    run_op(2'b00, 8'h00, 1'b1, 10, 1'b1);
    repeat (2) @(negedge clk);
    chk("R9 idle after poke", busy, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule